// File: doc/BRIEF.md
# Keyboard Serial Receiver with Clock-Hold Flow Control

This block takes scan-code bytes from a keyboard over a two-wire serial link made of a clock line and a data line. Transfers go only from the keyboard to the host. The block samples each bit on the falling edge of the keyboard clock and checks odd parity and the stop bit. It places every good byte in a hold register and raises a ready flag.

While a byte is waiting, the block pulls the open-drain clock line low so that the keyboard cannot start another frame. The CPU sees two read-only I/O registers: a data register and a status register. It reads them with an address and a one-cycle read strobe. A strobed read of the data register clears the ready flag and lets the clock line go.

Both inputs pass through two-flop synchronizers. The clock input is also glitch-filtered. A frame that stalls in the middle for longer than a timeout is dropped, and the receiver goes back to waiting for a start bit.

Top module: `ps2_inhibit_rx`

## Requirements
- R1: After reset the ready flag is 0, the clock line is released (`ps2ClkDriveLow` = 0) and the data register reads 0x00.
- R2: A frame is a start bit of 0, eight data bits LSB first, an odd parity bit and a stop bit of 1, each taken on a falling clock edge. After a good frame, the data register at `DATA_ADDR` (0xF4) holds the byte and status bit 0 at `STAT_ADDR` (0xF5) reads 1.
- R3: Status bits 7..1 read the same values as data register bits 7..1, and status bit 0 is the ready flag. A read at any other address returns 0x00.
- R4: While the ready flag is set, `ps2ClkDriveLow` is 1 and stays 1 until the data register is read with the strobe. No new byte is loaded over a pending one.
- R5: A strobed read of the data register clears the ready flag and releases the clock line on the next clock edge. A strobed read of the status register changes neither.
- R6: A frame whose parity is even (bad) is discarded: the ready flag and the data register keep their values.
- R7: A frame whose stop bit is 0 is discarded: the ready flag and the data register keep their values.
- R8: A falling clock edge while the data line is high does not start a frame.
- R9: A low pulse on the clock input shorter than `FILTER_CYCLES` system cycles is ignored.
- R10: If no falling clock edge arrives for `TIMEOUT_CYCLES` cycles in the middle of a frame, the partial frame is dropped and the next start bit begins a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ps2ClkIn | input | 1 | Level sensed on the keyboard clock line |
| ps2DataIn | input | 1 | Level sensed on the keyboard data line |
| ps2ClkDriveLow | output | 1 | 1 pulls the open-drain clock line low |
| rdStrobe | input | 1 | One-cycle read strobe |
| rdAddr | input | ADDR_W | I/O read address |
| rdData | output | 8 | Read data, combinational from the address |

## Verification
The last falling clock edge of a frame is seen through 2 synchronizer flops, the glitch filter (`FILTER_CYCLES`) and one edge-detect flop. The frame check then takes one more cycle, so a result shows at the ports about `FILTER_CYCLES`+4 cycles after that edge. The bench samples only after the keyboard model has finished the whole bit period that follows, which is well past that point. Register reads are combinational and are sampled 1 ns after the address is driven on a falling edge. The clearing effect of a strobed data read is due at the next rising edge, so the bench samples it at the falling edge after that. The timeout case waits `TIMEOUT_CYCLES` plus a margin before it sends the next frame.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_CHECK = 2'd2
  } rxState_e;

  typedef struct packed {
    logic clrShift;
    logic shiftBit;
    logic loadHold;
  } dpStrobes_t;
endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/ps2_rx_datapath.sv
module ps2_rx_datapath
  import ps2_rx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FILTER_CYCLES = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ps2ClkIn,
  input  logic              ps2DataIn,
  input  dpStrobes_t        strobes,
  output logic              clkFall,
  output logic              dataBit,
  output logic              frameOk,
  output logic [DATA_W-1:0] holdData
);
  localparam int SHIFT_W = DATA_W + 2;
  localparam int FCNT_W  = $clog2(FILTER_CYCLES + 1);

  logic [1:0] rawIn;
  logic [1:0] syncIn;
  assign rawIn = {ps2DataIn, ps2ClkIn};

  // one synchronizer per input line
  for (genvar g = 0; g < 2; g++) begin : gSync
    ps2_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSync (
      .clk(clk), .rstN(rstN), .asyncIn(rawIn[g]), .syncOut(syncIn[g])
    );
  end

  logic clkSync;
  assign clkSync = syncIn[0];
  assign dataBit = syncIn[1];

  // glitch filter: the filtered clock follows only a level held FILTER_CYCLES cycles
  logic              clkFilt;
  logic              clkFiltPrev;
  logic [FCNT_W-1:0] filtCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkFilt <= 1'b1;
      filtCnt <= '0;
    end else if (clkSync == clkFilt) begin
      filtCnt <= '0;
    end else if (filtCnt == FCNT_W'(FILTER_CYCLES - 1)) begin
      clkFilt <= clkSync;
      filtCnt <= '0;
    end else begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) clkFiltPrev <= 1'b1;
    else       clkFiltPrev <= clkFilt;
  end

  assign clkFall = clkFiltPrev & ~clkFilt;

  // shift register: data bits, parity and stop, entering at the top (LSB first)
  logic [SHIFT_W-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrShift) shiftQ <= '0;
    else if (strobes.shiftBit)     shiftQ <= {dataBit, shiftQ[SHIFT_W-1:1]};
  end

  // stop bit must be 1 and data plus parity must hold an odd number of ones
  assign frameOk = shiftQ[SHIFT_W-1] & (^shiftQ[SHIFT_W-2:0]);

  always_ff @(posedge clk) begin
    if (!rstN)                 holdData <= '0;
    else if (strobes.loadHold) holdData <= shiftQ[DATA_W-1:0];
  end
endmodule

// File: rtl/ps2_rx_ctrl.sv
module ps2_rx_ctrl
  import ps2_rx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int TIMEOUT_CYCLES = 200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkFall,
  input  logic       dataBit,
  input  logic       frameOk,
  input  logic       rdClear,
  output dpStrobes_t strobes,
  output logic       readyQ
);
  localparam int LAST_BIT = DATA_W + 1;  // index of the stop bit after the start bit
  localparam int BCNT_W   = $clog2(LAST_BIT + 1);
  localparam int TCNT_W   = $clog2(TIMEOUT_CYCLES + 1);

  rxState_e          stateQ, stateD;
  logic [BCNT_W-1:0] bitCntQ, bitCntD;
  logic [TCNT_W-1:0] idleCntQ, idleCntD;
  logic              setReady;

  always_comb begin
    stateD   = stateQ;
    bitCntD  = bitCntQ;
    idleCntD = idleCntQ;
    strobes  = '0;
    setReady = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        idleCntD = '0;
        // a start bit counts only when the line is not held and data is low
        if (clkFall && !readyQ && !dataBit) begin
          strobes.clrShift = 1'b1;
          bitCntD          = '0;
          stateD           = ST_RECV;
        end
      end
      ST_RECV: begin
        if (clkFall) begin
          strobes.shiftBit = 1'b1;
          idleCntD         = '0;
          if (bitCntQ == BCNT_W'(LAST_BIT)) stateD = ST_CHECK;
          else                              bitCntD = bitCntQ + 1'b1;
        end else if (idleCntQ == TCNT_W'(TIMEOUT_CYCLES - 1)) begin
          stateD = ST_IDLE;
        end else begin
          idleCntD = idleCntQ + 1'b1;
        end
      end
      ST_CHECK: begin
        if (frameOk && !readyQ) begin
          strobes.loadHold = 1'b1;
          setReady         = 1'b1;
        end
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      bitCntQ  <= '0;
      idleCntQ <= '0;
    end else begin
      stateQ   <= stateD;
      bitCntQ  <= bitCntD;
      idleCntQ <= idleCntD;
    end
  end

  // a new byte wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)         readyQ <= 1'b0;
    else if (setReady) readyQ <= 1'b1;
    else if (rdClear)  readyQ <= 1'b0;
  end
endmodule

// File: rtl/ps2_inhibit_rx.sv
module ps2_inhibit_rx
  import ps2_rx_pkg::*;
#(
  parameter int          ADDR_W         = 8,
  parameter logic [7:0]  DATA_ADDR      = 8'hF4,
  parameter logic [7:0]  STAT_ADDR      = 8'hF5,
  parameter int          FILTER_CYCLES  = 100,
  parameter int          TIMEOUT_CYCLES = 200000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ps2ClkIn,
  input  logic              ps2DataIn,
  output logic              ps2ClkDriveLow,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  localparam int DATA_W = 8;

  dpStrobes_t        strobes;
  logic              clkFall;
  logic              dataBit;
  logic              frameOk;
  logic              readyQ;
  logic              rdClear;
  logic [DATA_W-1:0] holdData;

  ps2_rx_datapath #(
    .DATA_W(DATA_W), .FILTER_CYCLES(FILTER_CYCLES), .SYNC_STAGES(2)
  ) uDp (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2ClkIn), .ps2DataIn(ps2DataIn),
    .strobes(strobes), .clkFall(clkFall), .dataBit(dataBit),
    .frameOk(frameOk), .holdData(holdData)
  );

  ps2_rx_ctrl #(
    .DATA_W(DATA_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clkFall(clkFall), .dataBit(dataBit),
    .frameOk(frameOk), .rdClear(rdClear), .strobes(strobes), .readyQ(readyQ)
  );

  assign rdClear        = rdStrobe && (rdAddr == ADDR_W'(DATA_ADDR));
  assign ps2ClkDriveLow = readyQ;

  always_comb begin
    if (rdAddr == ADDR_W'(DATA_ADDR))      rdData = holdData;
    else if (rdAddr == ADDR_W'(STAT_ADDR)) rdData = {holdData[7:1], readyQ};
    else                                   rdData = '0;
  end
endmodule

// File: rtl/ps2_rx_checker.sv
module ps2_rx_checker #(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] DATA_ADDR = 8'hF4,
  parameter logic [7:0] STAT_ADDR = 8'hF5
) (
  input logic              clk,
  input logic              rstN,
  input logic              ps2ClkDriveLow,
  input logic              rdStrobe,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              readyFlag,
  input logic              loadHold,
  input logic [7:0]        holdData
);
  logic rdClr;
  assign rdClr = rdStrobe && (rdAddr == ADDR_W'(DATA_ADDR));

  // R6/R7: the hold register changes only together with a new ready flag
  assert_hold_on_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(holdData) |-> $rose(readyFlag));

  // R4: the line stays held while a byte waits and no data read arrives
  assert_inhibit_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readyFlag && !rdClr) |=> ps2ClkDriveLow);

  // R5: a data read with no new byte releases the line next cycle
  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdClr && !loadHold) |=> !ps2ClkDriveLow);

  // R4: no byte is loaded over a pending one
  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(loadHold && readyFlag));

  // R3: status register mirrors the upper data bits and shows the flag
  assert_status_mirror_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(STAT_ADDR)) |-> (rdData == {holdData[7:1], readyFlag}));
endmodule

bind ps2_inhibit_rx ps2_rx_checker #(
  .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .ps2ClkDriveLow(ps2ClkDriveLow),
  .rdStrobe(rdStrobe), .rdAddr(rdAddr), .rdData(rdData),
  .readyFlag(readyQ), .loadHold(strobes.loadHold), .holdData(holdData)
);

// File: tb/tb_ps2_inhibit_rx.sv
module tb_ps2_inhibit_rx;
  localparam int FILT    = 8;
  localparam int TMO     = 3000;
  localparam int HALF    = 40;
  localparam logic [7:0] DA = 8'hF4;
  localparam logic [7:0] SA = 8'hF5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       kbdClk = 1'b1;
  logic       kbdData = 1'b1;
  logic       ps2ClkDriveLow;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdData;
  logic       clkLine;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [7:0] expData  = 8'h00;
  logic       expReady = 1'b0;

  always #5 clk = ~clk;
  assign clkLine = kbdClk & ~ps2ClkDriveLow;

  ps2_inhibit_rx #(
    .ADDR_W(8), .DATA_ADDR(DA), .STAT_ADDR(SA),
    .FILTER_CYCLES(FILT), .TIMEOUT_CYCLES(TMO)
  ) dut (
    .clk(clk), .rstN(rstN), .ps2ClkIn(clkLine), .ps2DataIn(kbdData),
    .ps2ClkDriveLow(ps2ClkDriveLow), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic logic oddPar(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulseBit(input logic b);
    kbdData = b;
    waitCyc(HALF/2);
    kbdClk = 1'b0;
    waitCyc(HALF);
    kbdClk = 1'b1;
    waitCyc(HALF/2);
  endtask

  // kind: 0 good, 1 bad parity, 2 bad stop
  task automatic sendFrame(input logic [7:0] b, input int kind);
    logic par;
    logic stp;
    while (ps2ClkDriveLow) @(posedge clk);
    par = oddPar(b) ^ (kind == 1);
    stp = (kind != 2);
    pulseBit(1'b0);
    for (int i = 0; i < 8; i++) pulseBit(b[i]);
    pulseBit(par);
    pulseBit(stp);
    kbdData = 1'b1;
    waitCyc(HALF);
    if (kind == 0 && !expReady) begin
      expData  = b;
      expReady = 1'b1;
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  task automatic strobeRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    rdStrobe = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdStrobe = 1'b0;
    rdAddr = 8'h00;
    if (a == DA) expReady = 1'b0;
  endtask

  task automatic checkPending(input string tag);
    logic [7:0] v;
    peek(SA, v);
    chk({tag, " status"}, v, {expData[7:1], expReady});
    chk({tag, " drive"}, ps2ClkDriveLow, expReady);
    peek(DA, v);
    chk({tag, " data"}, v, expData);
  endtask

  task automatic consume(input string tag);
    logic [7:0] v;
    strobeRead(DA, v);
    chk({tag, " read data"}, v, expData);
    chk({tag, " ready after read"}, ps2ClkDriveLow, 1'b0);
    peek(SA, v);
    chk({tag, " status bit0 after read"}, v[0], 1'b0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);

    // R1: reset state
    peek(DA, v);
    chk("R1 data after reset", v, 8'h00);
    peek(SA, v);
    chk("R1 status after reset", v, 8'h00);
    chk("R1 drive after reset", ps2ClkDriveLow, 1'b0);

    // R2/R4: good frame, then status read leaves it pending (R5)
    sendFrame(8'hA5, 0);
    checkPending("R2 first byte");
    chk("R4 drive while pending", ps2ClkDriveLow, 1'b1);
    strobeRead(SA, v);
    chk("R5 status read value", v, {8'hA5 >> 1, 1'b1} & 8'hFF);
    waitCyc(3);
    chk("R5 status read keeps hold", ps2ClkDriveLow, 1'b1);
    consume("R5");

    // R3: other addresses read zero, status mirrors upper bits
    sendFrame(8'hFE, 0);
    peek(8'h10, v);
    chk("R3 other address", v, 8'h00);
    peek(SA, v);
    chk("R3 mirror", v, 8'hFF);
    consume("R3");

    // R6: bad parity leaves register and flag
    sendFrame(8'h3C, 1);
    checkPending("R6 bad parity");
    // R7: bad stop bit
    sendFrame(8'h81, 2);
    checkPending("R7 bad stop");

    // R8: an edge with data high is not a start bit
    pulseBit(1'b1);
    waitCyc(HALF);
    sendFrame(8'h5A, 0);
    checkPending("R8 start high ignored");
    consume("R8");

    // R9: short glitch with data low is filtered out
    kbdData = 1'b0;
    waitCyc(10);
    kbdClk = 1'b0;
    waitCyc(FILT - 4);
    kbdClk = 1'b1;
    waitCyc(20);
    kbdData = 1'b1;
    waitCyc(HALF);
    sendFrame(8'h96, 0);
    checkPending("R9 glitch ignored");
    consume("R9");

    // R10: stalled frame times out, next frame is clean
    pulseBit(1'b0);
    pulseBit(1'b1);
    pulseBit(1'b0);
    pulseBit(1'b1);
    kbdData = 1'b1;
    waitCyc(TMO + 200);
    checkPending("R10 partial frame dropped");
    sendFrame(8'hC3, 0);
    checkPending("R10 after timeout");
    consume("R10");

    // random mix of good and corrupted frames (R2, R6, R7)
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      int kind;
      b = 8'($urandom);
      kind = int'($urandom % 3);
      sendFrame(b, kind);
      checkPending("R2/R6/R7 random");
      if (expReady) consume("R5 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule